// File: doc/BRIEF.md
# Dual-LUT Configurable Logic Cell

This block is one configurable logic cell. It contains two 4-input lookup tables, F and G. A 3-input combiner, H, takes the two table outputs and one extra pin. Two storage elements, X and Y, complete the cell. A static configuration vector sets how each part behaves. Either lookup table can also serve as a small writable memory of 16 one-bit words, in a single-port or a dual-port form. Each storage element can be an edge flip-flop or a level latch. Its clock polarity, clock enable and set/reset style are chosen per element.

The configuration is meant to be loaded while `rst_n` is low. Reset copies the lookup-table contents from the configuration into the table storage. It also forces each storage element to its configured set/reset value. After reset the tables answer combinationally. When a table is in a RAM mode it accepts writes on the rising edge of `clk`.

Top module: `dual_lut_cell`

## Requirements
- R1: With a table in logic mode (mode code 0), its output equals bit `tab[addr]` of its configured 16-bit truth table, as loaded at reset, and asserting its write enable changes nothing.
- R2: The H output equals bit `h_tab[{h_in, g, f}]` of the 8-bit H table: h_in is the most significant index bit, f the least.
- R3: In single-port RAM mode (mode code 1), a rising `clk` edge with write enable high stores the write data at the word addressed by the table inputs, and the output reads that same word.
- R4: During the cycle of a write, the output still shows the old word; the new value appears only after the edge.
- R5: In dual-port RAM mode (mode code 2), writes go to the address on the table inputs, while the output reads the word at the separate read address, independently.
- R6: In flip-flop mode a storage element captures its data on its active edge (rising `clk`, or falling when the clock-invert bit is set) only while its clock enable is high, and otherwise holds.
- R7: In latch mode a storage element is transparent while its active level holds (clk high, or low when inverted) and its enable is high, and holds at all other times.
- R8: With synchronous set/reset, a high `sr` loads the configured set/reset value on the active edge, ahead of the clock enable, and has no effect before that edge.
- R9: With asynchronous set/reset, a high `sr` forces the configured value at once, without any clock edge.
- R10: While `rst_n` is low, each storage element is loaded with its configured set/reset value, at its active edge in flip-flop mode or at once in latch mode.
- R11: Each element's data source and its combinational output are chosen by 2-bit codes: 0 = F, 1 = G, 2 = H, 3 = the element's direct input `d_dir`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock; RAM writes on the rising edge |
| rst_n | input | 1 | Active-low reset; loads tables and storage initial values |
| cfg | input | 60 | Static configuration, laid out as `dlc_pkg::cell_cfg_t` |
| f_in | input | 4 | F table inputs, also the write address |
| g_in | input | 4 | G table inputs, also the write address |
| f_rd | input | 4 | F read address in dual-port mode |
| g_rd | input | 4 | G read address in dual-port mode |
| f_wd | input | 1 | F write data |
| g_wd | input | 1 | G write data |
| f_we | input | 1 | F write enable |
| g_we | input | 1 | G write enable |
| h_in | input | 1 | Extra input of the H combiner |
| d_dir | input | 2 | Direct data for X (bit 0) and Y (bit 1) |
| ce | input | 2 | Clock enables for X and Y |
| sr | input | 2 | Set/reset requests for X and Y |
| c_out | output | 2 | Selected combinational outputs for X and Y |
| q_out | output | 2 | Storage outputs for X and Y |

## Verification
Two pairs of events can meet in one cycle. In the first, a write and a read hit the same table word. The bench holds the address and the write enable across a rising edge. It checks that the output still shows the old word before the edge and the written word after it. In the second, a set/reset request meets an active clock enable with opposite data. The bench raises both `sr` and `ce` with data of the other value. It checks that the set/reset value wins at the edge in the synchronous style. In the asynchronous style it checks that the value appears at once, before any edge.

// File: rtl/dlc_pkg.sv
// Shared constants and configuration types for the dual-LUT logic cell.
// Assumes the configuration is static outside of reset.
package dlc_pkg;
    localparam int LUT_IN    = 4;
    localparam int LUT_DEPTH = 1 << LUT_IN;
    localparam int H_IN      = 3;
    localparam int H_DEPTH   = 1 << H_IN;
    localparam int NUM_GEN   = 2;   // 0 = F, 1 = G
    localparam int NUM_ELEM  = 2;   // 0 = X, 1 = Y
    localparam int NUM_SRC   = 4;

    typedef enum logic [1:0] {
        LM_LOGIC = 2'd0,
        LM_RAM   = 2'd1,
        LM_DPRAM = 2'd2,
        LM_RSVD  = 2'd3
    } lut_mode_e;

    typedef enum logic [1:0] {
        SRC_F   = 2'd0,
        SRC_G   = 2'd1,
        SRC_H   = 2'd2,
        SRC_DIR = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic     latch_en;
        logic     clk_inv;
        logic     sr_sync;
        logic     sr_val;
        src_sel_e d_sel;
        src_sel_e o_sel;
    } elem_cfg_t;

    typedef struct packed {
        lut_mode_e              mode;
        logic [LUT_DEPTH-1:0]   tab;
    } lut_cfg_t;

    typedef struct packed {
        elem_cfg_t [NUM_ELEM-1:0] elem;
        logic [H_DEPTH-1:0]       h_tab;
        lut_cfg_t [NUM_GEN-1:0]   lut;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/dlc_lut.sv
// One 4-input function generator that can double as a 16x1 RAM.
// Contents load from the truth table while rst_n is low; writes are allowed
// only in the two RAM modes and land on the rising clk edge.
module dlc_lut
    import dlc_pkg::*;
#(
    parameter int IN = LUT_IN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [(1<<IN)-1:0] init_tab,
    input  lut_mode_e         mode,
    input  logic [IN-1:0]     wr_addr,
    input  logic [IN-1:0]     rd_addr,
    input  logic              wd,
    input  logic              we,
    output logic              val
);
    localparam int DEPTH = 1 << IN;

    logic [DEPTH-1:0] mem;
    logic             wr_ok;
    logic [IN-1:0]    rsel;

    // Decide whether writes are legal and which address is read.
    always_comb begin
        wr_ok = (mode == LM_RAM) || (mode == LM_DPRAM);
        rsel  = (mode == LM_DPRAM) ? rd_addr : wr_addr;
    end

    // Table storage: load on reset, write in RAM modes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= init_tab;
        end else if (wr_ok && we) begin
            mem[wr_addr] <= wd;
        end
    end

    // Asynchronous read: shows the pre-edge word during a write cycle.
    assign val = mem[rsel];
endmodule

// File: rtl/dlc_hgen.sv
// Small combiner: any function of N inputs, given as a 2**N-bit table.
module dlc_hgen #(
    parameter int N = 3
) (
    input  logic [(1<<N)-1:0] tab,
    input  logic [N-1:0]      sel,
    output logic              val
);
    // Table lookup by the concatenated inputs.
    assign val = tab[sel];
endmodule

// File: rtl/dlc_store.sv
// One storage element with its output selectors. Acts as a flip-flop on the
// active clock edge or as a latch on the active level; set/reset is
// synchronous or asynchronous per configuration. Assumes cfg static.
module dlc_store
    import dlc_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  elem_cfg_t       cfg,
    input  logic [NSRC-1:0] src,
    input  logic            ce,
    input  logic            sr,
    output logic            comb_o,
    output logic            q
);
    logic d;
    logic eclk;
    logic arst;
    logic srs;
    logic fq;
    logic lq;

    // Source selection and effective clock/reset nets.
    always_comb begin
        d      = src[cfg.d_sel];
        comb_o = src[cfg.o_sel];
        eclk   = clk ^ cfg.clk_inv;
        arst   = sr & ~cfg.sr_sync;
        srs    = sr & cfg.sr_sync;
    end

    // Edge storage with optional asynchronous set/reset.
    always_ff @(posedge eclk or posedge arst) begin
        if (arst) begin
            fq <= cfg.sr_val;
        end else if (!rst_n) begin
            fq <= cfg.sr_val;
        end else if (srs) begin
            fq <= cfg.sr_val;
        end else if (ce) begin
            fq <= d;
        end
    end

    // Level storage: transparent while eclk high and enabled.
    always_latch begin
        if (!rst_n) begin
            lq <= cfg.sr_val;
        end else if (arst || (srs && eclk)) begin
            lq <= cfg.sr_val;
        end else if (eclk && ce) begin
            lq <= d;
        end
    end

    // Pick the storage style in use.
    assign q = cfg.latch_en ? lq : fq;
endmodule

// File: rtl/dual_lut_cell.sv
// Top of the configurable logic cell: two lookup tables (F, G), the
// H combiner and two storage elements (X, Y). The configuration vector is
// static and is expected to change only while rst_n is low.
module dual_lut_cell
    import dlc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CFG_W-1:0]   cfg,
    input  logic [LUT_IN-1:0]  f_in,
    input  logic [LUT_IN-1:0]  g_in,
    input  logic [LUT_IN-1:0]  f_rd,
    input  logic [LUT_IN-1:0]  g_rd,
    input  logic               f_wd,
    input  logic               g_wd,
    input  logic               f_we,
    input  logic               g_we,
    input  logic               h_in,
    input  logic [NUM_ELEM-1:0] d_dir,
    input  logic [NUM_ELEM-1:0] ce,
    input  logic [NUM_ELEM-1:0] sr,
    output logic [NUM_ELEM-1:0] c_out,
    output logic [NUM_ELEM-1:0] q_out
);
    cell_cfg_t           cfg_s;
    logic [LUT_IN-1:0]   wa   [NUM_GEN];
    logic [LUT_IN-1:0]   ra   [NUM_GEN];
    logic [NUM_GEN-1:0]  wdv;
    logic [NUM_GEN-1:0]  wev;
    logic [NUM_GEN-1:0]  lut_val;
    logic                h_val;

    // Gather the per-table inputs into arrays for the generate loop.
    always_comb begin
        cfg_s  = cell_cfg_t'(cfg);
        wa[0]  = f_in;
        wa[1]  = g_in;
        ra[0]  = f_rd;
        ra[1]  = g_rd;
        wdv    = {g_wd, f_wd};
        wev    = {g_we, f_we};
    end

    for (genvar i = 0; i < NUM_GEN; i++) begin : g_lut
        dlc_lut #(.IN(LUT_IN)) u_lut (
            .clk      (clk),
            .rst_n    (rst_n),
            .init_tab (cfg_s.lut[i].tab),
            .mode     (cfg_s.lut[i].mode),
            .wr_addr  (wa[i]),
            .rd_addr  (ra[i]),
            .wd       (wdv[i]),
            .we       (wev[i]),
            .val      (lut_val[i])
        );
    end

    dlc_hgen #(.N(H_IN)) u_hgen (
        .tab (cfg_s.h_tab),
        .sel ({h_in, lut_val[1], lut_val[0]}),
        .val (h_val)
    );

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
        dlc_store #(.NSRC(NUM_SRC)) u_store (
            .clk    (clk),
            .rst_n  (rst_n),
            .cfg    (cfg_s.elem[e]),
            .src    ({d_dir[e], h_val, lut_val[1], lut_val[0]}),
            .ce     (ce[e]),
            .sr     (sr[e]),
            .comb_o (c_out[e]),
            .q      (q_out[e])
        );
    end
endmodule

// File: rtl/dlc_checks.sv
// Property checker for dual_lut_cell, attached by bind. Watches the F table
// and the X storage element.
module dlc_checks
    import dlc_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input cell_cfg_t           cfg_s,
    input logic [LUT_IN-1:0]   f_in,
    input logic                f_wd,
    input logic                f_we,
    input logic [NUM_GEN-1:0]  lut_val,
    input logic [NUM_ELEM-1:0] ce,
    input logic [NUM_ELEM-1:0] sr,
    input logic [NUM_ELEM-1:0] q_out
);
    logic x_edge_ff;
    assign x_edge_ff = !cfg_s.elem[0].latch_en && !cfg_s.elem[0].clk_inv;

    assert_logic_lookup_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_s.lut[0].mode == LM_LOGIC) |-> (lut_val[0] == cfg_s.lut[0].tab[f_in]));

    assert_ram_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cfg_s.lut[0].mode == LM_RAM && $past(f_we) && f_in == $past(f_in))
        |-> (lut_val[0] == $past(f_wd)));

    assert_hold_no_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (x_edge_ff && !sr[0] && !ce[0]) |=> ($stable(q_out[0]) || sr[0]));

    assert_sync_sr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (x_edge_ff && cfg_s.elem[0].sr_sync && sr[0]) |=> (q_out[0] == cfg_s.elem[0].sr_val));
endmodule

bind dual_lut_cell dlc_checks u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_s   (cfg_s),
    .f_in    (f_in),
    .f_wd    (f_wd),
    .f_we    (f_we),
    .lut_val (lut_val),
    .ce      (ce),
    .sr      (sr),
    .q_out   (q_out)
);

// File: tb/dual_lut_cell_bench.sv
// Directed bench for dual_lut_cell: one task per scenario.
module dual_lut_cell_bench;
    import dlc_pkg::*;

    localparam int CLK_P = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CFG_W-1:0]  cfg = '0;
    logic [3:0]        f_in = '0, g_in = '0, f_rd = '0, g_rd = '0;
    logic              f_wd = 0, g_wd = 0, f_we = 0, g_we = 0, h_in = 0;
    logic [1:0]        d_dir = '0, ce = '0, sr = '0;
    logic [1:0]        c_out, q_out;

    int n_run = 0;
    int n_fail = 0;

    dual_lut_cell u_dual_lut_cell (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .f_in(f_in), .g_in(g_in), .f_rd(f_rd), .g_rd(g_rd),
        .f_wd(f_wd), .g_wd(g_wd), .f_we(f_we), .g_we(g_we),
        .h_in(h_in), .d_dir(d_dir), .ce(ce), .sr(sr),
        .c_out(c_out), .q_out(q_out)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    function automatic cell_cfg_t base_cfg();
        cell_cfg_t c;
        c = '0;
        return c;
    endfunction

    // Load a configuration under reset, then release.
    task automatic apply_cfg(input cell_cfg_t c);
        tick();
        rst_n = 0; f_we = 0; g_we = 0; ce = '0; sr = '0;
        cfg = c;
        tick();
        tick();
        rst_n = 1;
        #1;
    endtask

    // R10: storage elements hold their set/reset values after reset.
    task automatic t_reset();
        cell_cfg_t c = base_cfg();
        c.elem[0].sr_val = 1'b1;
        c.elem[1].sr_val = 1'b0;
        apply_cfg(c);
        chk("R10 flop init", {6'd0, q_out}, 8'h01);
        c.elem[0].sr_val = 1'b0; c.elem[0].latch_en = 1'b1;
        c.elem[1].sr_val = 1'b1; c.elem[1].latch_en = 1'b1;
        apply_cfg(c);
        chk("R10 latch init", {6'd0, q_out}, 8'h02);
    endtask

    // R1 R2 R11: random truth tables against a lookup model.
    task automatic t_logic();
        for (int it = 0; it < 6; it++) begin
            cell_cfg_t c = base_cfg();
            logic [15:0] ft = 16'($urandom);
            logic [15:0] gt = 16'($urandom);
            logic [7:0]  ht = 8'($urandom);
            c.lut[0].tab = ft; c.lut[1].tab = gt; c.h_tab = ht;
            c.elem[0].o_sel = SRC_F; c.elem[1].o_sel = SRC_G;
            apply_cfg(c);
            for (int k = 0; k < 6; k++) begin
                f_in = 4'($urandom); g_in = 4'($urandom);
                #1;
                chk("R1 F lookup", {7'd0, c_out[0]}, {7'd0, ft[f_in]});
                chk("R1 G lookup", {7'd0, c_out[1]}, {7'd0, gt[g_in]});
            end
            c.elem[0].o_sel = SRC_H; c.elem[1].o_sel = SRC_DIR;
            apply_cfg(c);
            for (int k = 0; k < 6; k++) begin
                f_in = 4'($urandom); g_in = 4'($urandom);
                h_in = 1'($urandom); d_dir[1] = 1'($urandom);
                #1;
                chk("R2 H combine", {7'd0, c_out[0]},
                    {7'd0, ht[{h_in, gt[g_in], ft[f_in]}]});
                chk("R11 direct out", {7'd0, c_out[1]}, {7'd0, d_dir[1]});
            end
        end
    endtask

    // R1: writes are ignored in logic mode.
    task automatic t_logic_nowrite();
        cell_cfg_t c = base_cfg();
        logic [15:0] ft = 16'hA5C3;
        c.lut[0].tab = ft; c.elem[0].o_sel = SRC_F;
        apply_cfg(c);
        f_in = 4'd2; f_wd = ~ft[2]; f_we = 1;
        tick();
        f_we = 0;
        #1;
        chk("R1 write ignored", {7'd0, c_out[0]}, {7'd0, ft[2]});
    endtask

    // R3 R4: single-port RAM, read-during-write gives old word.
    task automatic t_sp_ram();
        cell_cfg_t c = base_cfg();
        c.lut[0].mode = LM_RAM; c.lut[0].tab = 16'h0000; c.elem[0].o_sel = SRC_F;
        apply_cfg(c);
        for (int a = 0; a < 16; a += 3) begin
            logic nv = a[0] ^ a[2] ^ 1'b1;
            f_in = 4'(a); f_wd = nv; f_we = 1;
            #1;
            chk("R4 old data in write cycle", {7'd0, c_out[0]}, 8'h00);
            tick();
            f_we = 0;
            #1;
            chk("R3 written word", {7'd0, c_out[0]}, {7'd0, nv});
        end
        f_in = 4'd1;
        #1;
        chk("R3 untouched word", {7'd0, c_out[0]}, 8'h00);
    endtask

    // R5: dual-port RAM reads at its own address.
    task automatic t_dp_ram();
        cell_cfg_t c = base_cfg();
        c.lut[1].mode = LM_DPRAM; c.lut[1].tab = 16'h0000; c.elem[1].o_sel = SRC_G;
        apply_cfg(c);
        g_in = 4'd5; g_rd = 4'd5; g_wd = 1; g_we = 1;
        #1;
        chk("R5 pre-edge read", {7'd0, c_out[1]}, 8'h00);
        tick();
        g_in = 4'd9; g_wd = 1; g_we = 1;
        #1;
        chk("R5 read port independent", {7'd0, c_out[1]}, 8'h01);
        tick();
        g_we = 0; g_in = 4'd3; g_rd = 4'd9;
        #1;
        chk("R5 second word", {7'd0, c_out[1]}, 8'h01);
        g_rd = 4'd3;
        #1;
        chk("R5 unwritten word", {7'd0, c_out[1]}, 8'h00);
    endtask

    // R6: rising-edge flop with enable.
    task automatic t_flop();
        cell_cfg_t c = base_cfg();
        c.elem[0].d_sel = SRC_DIR; c.elem[0].sr_sync = 1;
        apply_cfg(c);
        d_dir[0] = 1; ce[0] = 1;
        #1;
        chk("R6 no change before edge", {7'd0, q_out[0]}, 8'h00);
        tick();
        chk("R6 capture", {7'd0, q_out[0]}, 8'h01);
        ce[0] = 0; d_dir[0] = 0;
        tick();
        chk("R6 hold with ce low", {7'd0, q_out[0]}, 8'h01);
    endtask

    // R6: inverted clock captures on the falling edge only.
    task automatic t_flop_inv();
        cell_cfg_t c = base_cfg();
        c.elem[1].d_sel = SRC_DIR; c.elem[1].clk_inv = 1; c.elem[1].sr_sync = 1;
        apply_cfg(c);
        @(posedge clk); #1;
        d_dir[1] = 1; ce[1] = 1;
        #1;
        chk("R6 inv no early capture", {7'd0, q_out[1]}, 8'h00);
        tick();
        chk("R6 inv falling capture", {7'd0, q_out[1]}, 8'h01);
        d_dir[1] = 0;
        @(posedge clk); #1;
        chk("R6 inv ignores rising", {7'd0, q_out[1]}, 8'h01);
        tick();
        chk("R6 inv next falling", {7'd0, q_out[1]}, 8'h00);
        ce[1] = 0;
    endtask

    // R7: latch transparency and hold.
    task automatic t_latch();
        cell_cfg_t c = base_cfg();
        c.elem[0].latch_en = 1; c.elem[0].d_sel = SRC_DIR; c.elem[0].sr_sync = 1;
        apply_cfg(c);
        tick();
        ce[0] = 1; d_dir[0] = 1;
        #1;
        chk("R7 opaque at low level", {7'd0, q_out[0]}, 8'h00);
        @(posedge clk); #1;
        chk("R7 transparent", {7'd0, q_out[0]}, 8'h01);
        d_dir[0] = 0; #1;
        chk("R7 follows low", {7'd0, q_out[0]}, 8'h00);
        d_dir[0] = 1; #1;
        chk("R7 follows high", {7'd0, q_out[0]}, 8'h01);
        tick();
        d_dir[0] = 0; #1;
        chk("R7 holds when closed", {7'd0, q_out[0]}, 8'h01);
        ce[0] = 0;
        @(posedge clk); #1;
        chk("R7 ce low blocks", {7'd0, q_out[0]}, 8'h01);
    endtask

    // R8: synchronous set/reset beats clock enable at the edge.
    task automatic t_sync_sr();
        cell_cfg_t c = base_cfg();
        c.elem[0].d_sel = SRC_DIR; c.elem[0].sr_sync = 1; c.elem[0].sr_val = 0;
        apply_cfg(c);
        d_dir[0] = 1; ce[0] = 1;
        tick();
        chk("R8 preload", {7'd0, q_out[0]}, 8'h01);
        sr[0] = 1; #1;
        chk("R8 no effect before edge", {7'd0, q_out[0]}, 8'h01);
        tick();
        chk("R8 sr wins over ce", {7'd0, q_out[0]}, 8'h00);
        sr[0] = 0;
        tick();
        chk("R8 release", {7'd0, q_out[0]}, 8'h01);
        ce[0] = 0;
    endtask

    // R9: asynchronous set/reset acts without an edge.
    task automatic t_async_sr();
        cell_cfg_t c = base_cfg();
        c.elem[1].d_sel = SRC_DIR; c.elem[1].sr_sync = 0; c.elem[1].sr_val = 1;
        apply_cfg(c);
        d_dir[1] = 0; ce[1] = 1;
        tick();
        chk("R9 preload", {7'd0, q_out[1]}, 8'h00);
        sr[1] = 1; #1;
        chk("R9 immediate", {7'd0, q_out[1]}, 8'h01);
        tick();
        sr[1] = 0; ce[1] = 0; #1;
        chk("R9 holds after release", {7'd0, q_out[1]}, 8'h01);
        ce[1] = 1;
        tick();
        chk("R9 normal capture resumes", {7'd0, q_out[1]}, 8'h00);
        ce[1] = 0;
    endtask

    // R11: storage data sources H and G.
    task automatic t_dsel();
        cell_cfg_t c = base_cfg();
        logic [15:0] ft = 16'($urandom);
        logic [15:0] gt = 16'($urandom);
        logic [7:0]  ht = 8'($urandom);
        c.lut[0].tab = ft; c.lut[1].tab = gt; c.h_tab = ht;
        c.elem[0].d_sel = SRC_H; c.elem[1].d_sel = SRC_G;
        c.elem[0].sr_sync = 1; c.elem[1].sr_sync = 1;
        apply_cfg(c);
        ce = 2'b11;
        for (int k = 0; k < 8; k++) begin
            logic eh, eg;
            f_in = 4'($urandom); g_in = 4'($urandom); h_in = 1'($urandom);
            eh = ht[{h_in, gt[g_in], ft[f_in]}];
            eg = gt[g_in];
            tick();
            chk("R11 X from H", {7'd0, q_out[0]}, {7'd0, eh});
            chk("R11 Y from G", {7'd0, q_out[1]}, {7'd0, eg});
        end
        ce = 2'b00;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_logic();
        t_logic_nowrite();
        t_sp_ram();
        t_dp_ram();
        t_flop();
        t_flop_inv();
        t_latch();
        t_sync_sr();
        t_async_sr();
        t_dsel();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule